// File: doc/BRIEF.md
# Throttled Interrupt Cause Unit

This unit gathers event pulses from a network controller's internal engines into a 31-bit cause register and drives one interrupt line to the host. A mask register picks which causes may raise the line. The host reaches the unit through a small 32-bit register port. Reading the cause register returns every pending cause plus a line-asserted flag in bit 31, and the read can clear the causes. Writing ones to the cause register clears the matching causes. An optional auto-mask feature removes a programmed set of bits from the mask whenever the host acknowledges.

A throttle interval, counted in units of 256 nanosecond strobes, spaces out assertions of the line. When the interval is zero, an unmasked cause raises the line on the next clock. When the interval is nonzero, the first unmasked cause starts a countdown, and the line rises when the countdown ends. An event source may ask for an immediate assertion that skips the countdown. The countdown is driven by a one-cycle nanosecond strobe input, so it does not depend on the system clock frequency.

Register offsets on `reg_addr`: 0 cause, 1 mask (write sets bits), 2 mask (write clears bits), 3 auto-mask bits, 4 throttle interval, 5 control (bit 0 enables auto-masking). Reads of offsets 1 and 2 both return the mask. Reads of unused offsets return zero.

Top module: `irq_throttle_unit`

## Requirements
- R1: After reset the cause, mask, auto-mask, interval and control registers all read zero, and `irq_o` is low.
- R2: A pulse on `evt_post[i]` sets cause bit i. Posting a bit that is already set leaves the cause register unchanged. No cause bit becomes set except through a post.
- R3: With an interval of zero, an unmasked cause raises `irq_o` on the clock edge that records it, and bit 31 of a cause read is then 1.
- R4: With an interval N > 0 and `ns_tick` high every cycle, a first unmasked post starts a countdown. `irq_o` rises exactly 256·N clock edges after the edge that records the post.
- R5: A post with `evt_now` high, which adds a new unmasked cause while no other unmasked cause is pending, raises `irq_o` on that edge even when the interval is nonzero.
- R6: A cause read returns {line flag, causes}. It clears bits 30:0 only if the flag is set or the mask is zero. Otherwise the causes are kept.
- R7: A cause read made while the flag is set and auto-masking is enabled removes the auto-mask bits from the mask.
- R8: A cause write clears each bit in 30:0 that is written as 1. With auto-masking enabled, it also removes the auto-mask bits from the mask.
- R9: A write to offset 1 ORs the data bits into the mask. A write to offset 2 clears the mask bits that are written as 1.
- R10: Whenever cause AND mask becomes zero, `irq_o` and the flag drop on that edge and any running countdown is cancelled.
- R11: The countdown advances only on cycles where `ns_tick` is high. With the strobe held low, the line never rises through the countdown.
- R12: Writes and posts cannot set or clear bit 31. It reflects only the line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_post | input | 31 | Event pulses, one per cause bit |
| evt_now | input | 1 | Request that this cycle's posts assert without throttling |
| ns_tick | input | 1 | One-cycle strobe once per nanosecond |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects apply at the edge) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
A wrong internal state shows at the ports within a cycle or two. `reg_rdata` exposes the cause, mask and flag on every cycle, so a missed clear, a stray bit or a lost auto-mask shows up on the next compare. Countdown errors are quieter: a counter that is off by one, or that advances without `ns_tick`, only shows when `irq_o` rises at the wrong edge, which can be 256·N cycles after the post. For that reason the bench checks every cycle of long throttle windows with the strobe held high, and also with the strobe held low.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;
  localparam int CAUSE_W = 31;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CAUSE    = 3'd0,
    RA_MASK_SET = 3'd1,
    RA_MASK_CLR = 3'd2,
    RA_AUTOMASK = 3'd3,
    RA_INTERVAL = 3'd4,
    RA_CTRL     = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_thr_pkg::*;
#(
  parameter int ITR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CAUSE_W-1:0] wdata,
  input  logic               strip,
  output logic [CAUSE_W-1:0] mask_q,
  output logic [CAUSE_W-1:0] mask_nxt,
  output logic [CAUSE_W-1:0] iam_q,
  output logic [ITR_W-1:0]   itr_q,
  output logic               ame_q
);
  logic set_we, clr_we, iam_we, itr_we, ctl_we;

  always_comb begin
    set_we = wr_en && (addr == RA_MASK_SET);
    clr_we = wr_en && (addr == RA_MASK_CLR);
    iam_we = wr_en && (addr == RA_AUTOMASK);
    itr_we = wr_en && (addr == RA_INTERVAL);
    ctl_we = wr_en && (addr == RA_CTRL);
    mask_nxt = mask_q;
    if (strip)  mask_nxt = mask_nxt & ~iam_q;
    if (set_we) mask_nxt = mask_nxt | wdata;
    if (clr_we) mask_nxt = mask_nxt & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      iam_q  <= '0;
      itr_q  <= '0;
      ame_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      if (iam_we) iam_q <= wdata;
      if (itr_we) itr_q <= wdata[ITR_W-1:0];
      if (ctl_we) ame_q <= wdata[0];
    end
  end

  AST_MASK_RISE_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & ~$past(mask_q) & ~($past(set_we) ? $past(wdata) : '0)) == '0)); // R9

  AST_MASK_DROP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mask_q & $past(mask_q) & ~($past(strip) ? $past(iam_q) : '0)
      & ~($past(clr_we) ? $past(wdata) : '0)) == '0)); // R7
endmodule

// File: rtl/irq_throttle_timer.sv
module irq_throttle_timer #(
  parameter int ITR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ns_tick,
  input  logic             arm,
  input  logic             cancel,
  input  logic [ITR_W-1:0] interval,
  output logic             expire,
  output logic             running
);
  localparam int CNT_W = ITR_W + 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    expire = run_q && ns_tick && (cnt_q == CNT_W'(1));
    run_d  = run_q;
    cnt_d  = cnt_q;
    if (cancel || expire) begin
      run_d = 1'b0;
    end else if (run_q && ns_tick) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (arm && !run_q && (interval != '0)) begin
      run_d = 1'b1;
      cnt_d = {interval, 8'h00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running = run_q;

  AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0)); // R4

  AST_TMR_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(ns_tick)) |-> (cnt_q == $past(cnt_q))); // R11
endmodule

// File: rtl/irq_throttle_unit.sv
module irq_throttle_unit
  import irq_thr_pkg::*;
#(
  parameter int ITR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] evt_post,
  input  logic               evt_now,
  input  logic               ns_tick,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d, cause_ack, fresh;
  logic [CAUSE_W-1:0] mask_q, mask_nxt, iam_q;
  logic [ITR_W-1:0]   itr_q;
  logic               ame_q, line_q, line_d;
  logic               cause_rd, cause_wr, strip, rd_clear;
  logic               pend_old, any_d, now_req, fire;
  logic               tmr_expire, tmr_run, tmr_arm, tmr_cancel;

  irq_cfg_regs #(.ITR_W(ITR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[CAUSE_W-1:0]), .strip(strip),
    .mask_q(mask_q), .mask_nxt(mask_nxt), .iam_q(iam_q),
    .itr_q(itr_q), .ame_q(ame_q)
  );

  irq_throttle_timer #(.ITR_W(ITR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ns_tick(ns_tick), .arm(tmr_arm),
    .cancel(tmr_cancel), .interval(itr_q), .expire(tmr_expire),
    .running(tmr_run)
  );

  always_comb begin
    cause_rd = reg_rd && (reg_addr == RA_CAUSE);
    cause_wr = reg_wr && (reg_addr == RA_CAUSE);
    strip    = ame_q && ((cause_rd && line_q) || cause_wr);
    rd_clear = cause_rd && (line_q || (mask_q == '0));
    cause_ack = rd_clear ? '0 : cause_q;
    if (cause_wr) cause_ack = cause_ack & ~reg_wdata[CAUSE_W-1:0];
    fresh    = evt_post & ~cause_ack;
    pend_old = |(cause_ack & mask_nxt);
    cause_d  = cause_ack | evt_post;
    any_d    = |(cause_d & mask_nxt);
    now_req  = (|(fresh & mask_nxt)) && !pend_old && evt_now;
    fire     = any_d && ((itr_q == '0) || now_req || tmr_expire);
    line_d   = any_d && (line_q || fire);
    tmr_cancel = !any_d || fire;
    tmr_arm    = any_d && !line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      line_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      line_q  <= line_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CAUSE:                 reg_rdata = {line_q, cause_q};
      RA_MASK_SET, RA_MASK_CLR: reg_rdata = {1'b0, mask_q};
      RA_AUTOMASK:              reg_rdata = {1'b0, iam_q};
      RA_INTERVAL:              reg_rdata = {{(32-ITR_W){1'b0}}, itr_q};
      RA_CTRL:                  reg_rdata = {31'd0, ame_q};
      default:                  reg_rdata = '0;
    endcase
  end

  assign irq_o = line_q;

  AST_LINE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> (|(cause_q & mask_q))); // R10

  AST_CAUSE_ONLY_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q) & ~$past(evt_post)) == '0)); // R2

  AST_LINE_RISE_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q) |-> $past((itr_q == '0) || tmr_expire || now_req)); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cause_wr) |->
      ((cause_q & $past(reg_wdata[CAUSE_W-1:0]) & ~$past(evt_post)) == '0)); // R8

  AST_TIMER_IDLE_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> !tmr_run); // R10
endmodule

// File: tb/tb_irq_throttle_unit.sv
`timescale 1ns/100ps
module tb_irq_throttle_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] evt_post = '0;
  logic        evt_now = 1'b0;
  logic        ns_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_throttle_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_post(evt_post), .evt_now(evt_now),
    .ns_tick(ns_tick), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  bit [30:0] m_cause, m_mask, m_iam;
  int        m_itr;
  bit        m_ame, m_line, m_run;
  int        m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = 0; m_mask = 0; m_iam = 0; m_itr = 0;
      m_ame = 0; m_line = 0; m_run = 0; m_left = 0;
    end else begin
      bit [30:0] c, mk, nb;
      bit pend, any, nowf, exp, fire, nl;
      c = m_cause; mk = m_mask;
      if (reg_rd && reg_addr == 0) begin
        if (m_line || m_mask == 0) c = 0;
        if (m_line && m_ame) mk = mk & ~m_iam;
      end
      if (reg_wr) begin
        case (reg_addr)
          0: begin if (m_ame) mk = mk & ~m_iam; c = c & ~reg_wdata[30:0]; end
          1: mk = mk | reg_wdata[30:0];
          2: mk = mk & ~reg_wdata[30:0];
          default: ;
        endcase
      end
      nb   = evt_post & ~c;
      pend = (c & mk) != 0;
      c    = c | evt_post;
      any  = (c & mk) != 0;
      nowf = ((nb & mk) != 0) && !pend && evt_now;
      exp  = m_run && ns_tick && m_left == 1;
      fire = any && (m_itr == 0 || nowf || exp);
      nl   = any && (m_line || fire);
      if (!any || fire || exp) m_run = 0;
      else if (m_run && ns_tick) m_left = m_left - 1;
      else if (!nl && !m_run && m_itr != 0) begin m_run = 1; m_left = m_itr * 256; end
      m_cause = c; m_mask = mk; m_line = nl;
      if (reg_wr && reg_addr == 3) m_iam = reg_wdata[30:0];
      if (reg_wr && reg_addr == 4) m_itr = int'(reg_wdata[15:0]);
      if (reg_wr && reg_addr == 5) m_ame = reg_wdata[0];
    end
  end

  function automatic bit [31:0] m_read(input bit [2:0] a);
    case (a)
      0: return {m_line, m_cause};
      1, 2: return {1'b0, m_mask};
      3: return {1'b0, m_iam};
      4: return m_itr[31:0];
      5: return {31'd0, m_ame};
      default: return 0;
    endcase
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      tests++;
      if (irq_o !== m_line || reg_rdata !== m_read(reg_addr)) begin
        fails++;
        $display("FAIL model R1-track: irq=%0b exp=%0b rdata=%h exp=%h (addr %0d, cycle %0d)",
                 irq_o, m_line, reg_rdata, m_read(reg_addr), reg_addr, cyc);
      end
    end
  end

  task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      reg_wr = 0; reg_rd = 0; evt_post = '0; evt_now = 0;
    end
  endtask

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
    idle(1);
  endtask

  task automatic rd(input bit [2:0] a, output bit [31:0] d);
    @(negedge clk); #1;
    reg_rd = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    idle(1);
  endtask

  task automatic post(input bit [30:0] b, input bit now);
    @(negedge clk); #1;
    evt_post = b; evt_now = now;
    idle(1);
  endtask

  initial begin : watchdog
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    bit [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle(1);
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 0);
    rd(0, d); check("R1 cause", d, 0);
    rd(1, d); check("R1 mask", d, 0);
    rd(4, d); check("R1 interval", d, 0);
    rd(5, d); check("R1 ctrl", d, 0);
    // R3 zero interval fires at once
    wr(1, 32'h5);
    post(31'h1, 0);
    check("R3 irq", {31'd0, irq_o}, 1);
    rd(0, d); check("R3 flag", d, 32'h8000_0001);
    check("R10 irq drop", {31'd0, irq_o}, 0);
    rd(0, d); check("R6 cleared", d, 0);
    // R6 masked cause kept while flag clear
    post(31'h2, 0);
    check("R6 masked irq", {31'd0, irq_o}, 0);
    rd(0, d); check("R6 read1", d, 32'h2);
    rd(0, d); check("R6 kept", d, 32'h2);
    // R2 repost no effect
    post(31'h2, 0);
    rd(0, d); check("R2 repost", d, 32'h2);
    wr(0, 32'h2);
    rd(0, d); check("R8 w1c", d, 0);
    // R12 bit31 not writable
    post(31'h4, 0);
    wr(0, 32'h8000_0000);
    rd(0, d); check("R12 flag kept", d, 32'h8000_0004);
    wr(0, 32'h4);
    check("R10 after w1c", {31'd0, irq_o}, 0);
    // R4 throttle window
    wr(4, 32'h1);
    ns_tick = 1;
    post(31'h1, 0);
    idle(255);
    check("R4 before", {31'd0, irq_o}, 0);
    idle(1);
    check("R4 at 256", {31'd0, irq_o}, 1);
    rd(0, d); check("R4 flag", d, 32'h8000_0001);
    // R11 no strobe, no fire
    ns_tick = 0;
    post(31'h1, 0);
    idle(600);
    check("R11 no tick", {31'd0, irq_o}, 0);
    wr(0, 32'h1);
    // R5 immediate
    post(31'h4, 1);
    check("R5 now", {31'd0, irq_o}, 1);
    // R7 auto-mask on read
    wr(5, 32'h1);
    wr(3, 32'h4);
    rd(0, d); check("R7 read", d, 32'h8000_0004);
    rd(1, d); check("R7 mask", d, 32'h1);
    // R8 auto-mask on write
    wr(1, 32'h4);
    wr(0, 32'h0);
    rd(2, d); check("R8 strip", d, 32'h1);
    // R9 set/clear
    wr(2, 32'h1);
    rd(1, d); check("R9 clr", d, 0);
    wr(1, 32'h3);
    rd(1, d); check("R9 set", d, 32'h3);
    // R10 cancel running timer
    wr(5, 32'h0);
    ns_tick = 1;
    post(31'h1, 0);
    idle(100);
    wr(2, 32'h1);
    idle(300);
    check("R10 cancel", {31'd0, irq_o}, 0);
    wr(1, 32'h1);
    idle(300);
    check("R4 rearm", {31'd0, irq_o}, 1);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule